// File: doc/BRIEF.md
# I2C Interrupt and DMA Request Controller

This block sits next to an I2C byte engine. It holds the engine's enable and its second control word, which carries a last-transfer flag, DMA and interrupt enables and a 6-bit clock frequency field. From the status flags that the engine reports, it forms three registered request lines: an event interrupt, an error interrupt and a DMA request.

A cleared peripheral enable does not stop the block in the middle of a transfer. The block stays active until the engine reports an idle bus, and only then goes quiet and clears its last-transfer flag. When the last-transfer flag is set, the next DMA end-of-transfer produces a one-cycle `nack_last` pulse that tells the engine to NACK the final received byte. The flag then clears itself.

Software writes through a simple port. `wr_sel`=0 selects the enable word, where bit 0 is the enable. `wr_sel`=1 selects control word 2. The current control word 2 is always visible on `ctrl2_rd`.

Top module: `i2c_evt_ctrl`

## Requirements
- R1: After a synchronous reset, `ctrl2_rd` reads 0x0000, `periph_active` is 0, and `evt_irq`, `err_irq`, `dma_req` and `nack_last` are all 0.
- R2: A write with `wr_sel`=1 stores control word 2. The field layout is: bit 12 last-transfer, bit 11 DMA enable, bit 10 buffer interrupt enable, bit 9 event interrupt enable, bit 8 error interrupt enable, and bits 5:0 frequency, which also drive `freq`. Bits 15:13 and 7:6 always read 0, so writing 0xFFFF reads back 0x1F3F.
- R3: A write with `wr_sel`=1... is not the enable path. A write with `wr_sel`=0 and bit 0 set to 1 makes `periph_active` 1 at that same clock edge. Writing bit 0 as 0 clears `periph_active` only at an edge where `bus_idle` is 1. Until then the block keeps working.
- R4: Each of the four outputs is registered one cycle after its inputs, and is 0 in the cycle after any cycle in which `periph_active` is 0.
- R5: `dma_req` is 1 when DMA enable is 1 and `txe` or `rxne` is 1.
- R6: With buffer interrupt enable at 1, `txe` or `rxne` raises `evt_irq`, whatever the DMA enable is. With it at 0, these two flags never raise `evt_irq`.
- R7: With event interrupt enable at 1, any of `sb`, `addr`, `add10` or `stopf` raises `evt_irq`. With it at 0, they do not.
- R8: `btf` raises `evt_irq` only when event interrupt enable is 1 and no buffer event (buffer interrupt enable together with `txe` or `rxne`) is pending.
- R9: `err_irq` is 1 when error interrupt enable is 1 and any bit of `err_flags` is 1.
- R10: While active and with last-transfer at 1, a `dma_eot` cycle gives a `nack_last` pulse of exactly one cycle on the next edge and clears last-transfer. Without last-transfer, `dma_eot` gives no pulse.
- R11: When the deferred disable finally takes effect, last-transfer is cleared. The other control word 2 fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: enable word, 1: control word 2 |
| wr_data | input | 16 | Write data |
| sb | input | 1 | Start bit sent (master) |
| addr | input | 1 | Address sent or matched |
| add10 | input | 1 | 10-bit header sent (master) |
| stopf | input | 1 | Stop detected (slave) |
| btf | input | 1 | Byte transfer finished |
| txe | input | 1 | Transmit data empty |
| rxne | input | 1 | Receive data not empty |
| err_flags | input | 4 | Bus error, arbitration lost, ack failure, overrun |
| bus_idle | input | 1 | Engine is back in idle |
| dma_eot | input | 1 | DMA end-of-transfer |
| ctrl2_rd | output | 16 | Control word 2 read view |
| freq | output | 6 | Frequency field to the engine |
| periph_active | output | 1 | Effective enable |
| evt_irq | output | 1 | Event interrupt |
| err_irq | output | 1 | Error interrupt |
| dma_req | output | 1 | DMA request |
| nack_last | output | 1 | NACK-final-byte pulse to the engine |

## Verification
The hardest state to reach is the window in which the enable bit has already been written to 0, but the block is still active because the bus is busy. The bench holds `bus_idle` low, clears the enable while a DMA request is live, and confirms that the request keeps running. It then releases `bus_idle` and checks the exact cycle at which the block goes inactive, the cycle after which the request drops, and that last-transfer is lost.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int CW_W    = 16;
  localparam int FREQ_W  = 6;
  localparam int ERR_W   = 4;
  localparam int B_LAST  = 12;
  localparam int B_DMA   = 11;
  localparam int B_BUF   = 10;
  localparam int B_EVT   = 9;
  localparam int B_ERR   = 8;

  typedef struct packed {
    logic              last;
    logic              dma_en;
    logic              buf_en;
    logic              evt_en;
    logic              err_en;
    logic [FREQ_W-1:0] freq;
  } cfg_t;

  typedef struct packed {
    logic sb;
    logic addr;
    logic add10;
    logic stopf;
    logic btf;
    logic txe;
    logic rxne;
  } evt_flags_t;
endpackage

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W = CW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bus_idle,
  input  logic              dma_eot,
  output cfg_t              cfg,
  output logic              active,
  output logic              nack_fire
);
  logic pe_req;
  logic pe_next;
  logic active_next;
  logic falling;
  logic wr_cw2;

  assign wr_cw2      = wr_en & wr_sel;
  assign pe_next     = (wr_en & ~wr_sel) ? wr_data[0] : pe_req;
  assign active_next = pe_next | (active & ~bus_idle);
  assign falling     = active & ~active_next;
  assign nack_fire   = active & cfg.last & dma_eot;

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_req <= 1'b0;
      active <= 1'b0;
    end else begin
      pe_req <= pe_next;
      active <= active_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_cw2) begin
      cfg.last   <= wr_data[B_LAST];
      cfg.dma_en <= wr_data[B_DMA];
      cfg.buf_en <= wr_data[B_BUF];
      cfg.evt_en <= wr_data[B_EVT];
      cfg.err_en <= wr_data[B_ERR];
      cfg.freq   <= wr_data[FREQ_W-1:0];
    end else if (nack_fire || falling) begin
      cfg.last   <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_combine.sv
module i2c_evt_combine
  import i2c_evt_pkg::*;
#(
  parameter int NERR = ERR_W
) (
  input  cfg_t            cfg,
  input  evt_flags_t      fl,
  input  logic [NERR-1:0] errs,
  output logic            evt_hit,
  output logic            err_hit,
  output logic            dma_hit
);
  logic buf_pending;
  logic ctl_evt;
  logic btf_evt;
  logic [NERR:0] err_chain;

  assign err_chain[0] = 1'b0;
  for (genvar i = 0; i < NERR; i++) begin : g_err
    assign err_chain[i+1] = err_chain[i] | errs[i];
  end

  always_comb begin
    buf_pending = cfg.buf_en & (fl.txe | fl.rxne);
    ctl_evt     = cfg.evt_en & (fl.sb | fl.addr | fl.add10 | fl.stopf);
    btf_evt     = cfg.evt_en & fl.btf & ~buf_pending;
    evt_hit     = buf_pending | ctl_evt | btf_evt;
    err_hit     = cfg.err_en & err_chain[NERR];
    dma_hit     = cfg.dma_en & (fl.txe | fl.rxne);
  end
endmodule

// File: rtl/i2c_req_out.sv
module i2c_req_out #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [N-1:0] req_in,
  output logic [N-1:0] req_q
);
  for (genvar i = 0; i < N; i++) begin : g_q
    always_ff @(posedge clk) begin
      if (rst) req_q[i] <= 1'b0;
      else     req_q[i] <= active & req_in[i];
    end
  end
endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W = CW_W,
  parameter int NERR   = ERR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sb,
  input  logic              addr,
  input  logic              add10,
  input  logic              stopf,
  input  logic              btf,
  input  logic              txe,
  input  logic              rxne,
  input  logic [NERR-1:0]   err_flags,
  input  logic              bus_idle,
  input  logic              dma_eot,
  output logic [DATA_W-1:0] ctrl2_rd,
  output logic [FREQ_W-1:0] freq,
  output logic              periph_active,
  output logic              evt_irq,
  output logic              err_irq,
  output logic              dma_req,
  output logic              nack_last
);
  localparam int NOUT = 4;

  cfg_t       cfg;
  evt_flags_t fl;
  logic       nack_fire;
  logic       evt_hit, err_hit, dma_hit;
  logic [NOUT-1:0] q;

  assign fl = '{sb: sb, addr: addr, add10: add10, stopf: stopf,
                btf: btf, txe: txe, rxne: rxne};

  i2c_ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bus_idle(bus_idle), .dma_eot(dma_eot), .cfg(cfg),
    .active(periph_active), .nack_fire(nack_fire)
  );

  i2c_evt_combine #(.NERR(NERR)) u_comb (
    .cfg(cfg), .fl(fl), .errs(err_flags),
    .evt_hit(evt_hit), .err_hit(err_hit), .dma_hit(dma_hit)
  );

  i2c_req_out #(.N(NOUT)) u_out (
    .clk(clk), .rst(rst), .active(periph_active),
    .req_in({nack_fire, dma_hit, err_hit, evt_hit}), .req_q(q)
  );

  assign evt_irq   = q[0];
  assign err_irq   = q[1];
  assign dma_req   = q[2];
  assign nack_last = q[3];
  assign freq      = cfg.freq;

  always_comb begin
    ctrl2_rd               = '0;
    ctrl2_rd[B_LAST]       = cfg.last;
    ctrl2_rd[B_DMA]        = cfg.dma_en;
    ctrl2_rd[B_BUF]        = cfg.buf_en;
    ctrl2_rd[B_EVT]        = cfg.evt_en;
    ctrl2_rd[B_ERR]        = cfg.err_en;
    ctrl2_rd[FREQ_W-1:0]   = cfg.freq;
  end
endmodule

// File: rtl/i2c_evt_ctrl_chk.sv
module i2c_evt_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_idle,
  input logic        dma_eot,
  input logic        txe,
  input logic        rxne,
  input logic [15:0] ctrl2_rd,
  input logic        periph_active,
  input logic        evt_irq,
  input logic        err_irq,
  input logic        dma_req,
  input logic        nack_last
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !periph_active |=> !evt_irq && !err_irq && !dma_req && !nack_last); // R4
  AST_DEFER_DISABLE: assert property (@(posedge clk) disable iff (rst)
    periph_active && !bus_idle |=> periph_active); // R3
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(ctrl2_rd[11]) && ($past(txe) || $past(rxne))); // R5
  AST_ERR_ENABLED: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> $past(ctrl2_rd[8])); // R9
  AST_NACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    nack_last |-> $past(ctrl2_rd[12]) && $past(dma_eot)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl2_rd[15:13] == 3'b000 && ctrl2_rd[7:6] == 2'b00); // R2
endmodule

bind i2c_evt_ctrl i2c_evt_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_idle(bus_idle), .dma_eot(dma_eot),
  .txe(txe), .rxne(rxne), .ctrl2_rd(ctrl2_rd),
  .periph_active(periph_active), .evt_irq(evt_irq), .err_irq(err_irq),
  .dma_req(dma_req), .nack_last(nack_last)
);

// File: tb/test_i2c_evt_ctrl.sv
`timescale 1ns/1ps
module test_i2c_evt_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic sb = 0, addr = 0, add10 = 0, stopf = 0, btf = 0, txe = 0, rxne = 0;
  logic [3:0] err_flags = 0;
  logic bus_idle = 1, dma_eot = 0;
  logic [15:0] ctrl2_rd;
  logic [5:0] freq;
  logic periph_active, evt_irq, err_irq, dma_req, nack_last;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  i2c_evt_ctrl i_i2c_evt_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sb(sb), .addr(addr), .add10(add10), .stopf(stopf), .btf(btf),
    .txe(txe), .rxne(rxne), .err_flags(err_flags), .bus_idle(bus_idle),
    .dma_eot(dma_eot), .ctrl2_rd(ctrl2_rd), .freq(freq),
    .periph_active(periph_active), .evt_irq(evt_irq), .err_irq(err_irq),
    .dma_req(dma_req), .nack_last(nack_last)
  );

  // {cfg[15:0], flags{sb,addr,add10,stopf,btf,txe,rxne,err[3:0]}, exp{evt,err,dma}}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {16'h0200, 11'b1000000_0000, 3'b100},  // R7 sb
    {16'h0000, 11'b1000000_0000, 3'b000},  // R7 disabled
    {16'h0200, 11'b0100000_0000, 3'b100},  // R7 addr
    {16'h0200, 11'b0010000_0000, 3'b100},  // R7 add10
    {16'h0200, 11'b0001000_0000, 3'b100},  // R7 stopf
    {16'h0200, 11'b0000100_0000, 3'b100},  // R8 btf
    {16'h0400, 11'b0000100_0000, 3'b000},  // R8 btf needs evt enable
    {16'h0400, 11'b0000010_0000, 3'b100},  // R6 txe
    {16'h0200, 11'b0000011_0000, 3'b000},  // R6 no buf enable
    {16'h0800, 11'b0000001_0000, 3'b001},  // R5 rxne dma
    {16'h0E00, 11'b0000010_0000, 3'b101},  // R5 R6 both
    {16'h0100, 11'b0000000_0100, 3'b010},  // R9 error
    {16'h0000, 11'b0000000_1111, 3'b000},  // R9 disabled
    {16'h0B00, 11'b0000000_0000, 3'b000}   // R7 nothing pending
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_flags(input logic [10:0] f);
    {sb, addr, add10, stopf, btf, txe, rxne, err_flags} = f;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 ctrl2", ctrl2_rd, 16'h0000);
    chk("R1 outs", {12'h0, periph_active, evt_irq, err_irq, dma_req}, 16'h0);

    // inactive: outputs stay 0
    wr(1, 16'h0B00);
    set_flags(11'b1000010_0001);
    @(negedge clk);
    chk("R4 quiet when off", {13'h0, evt_irq, err_irq, dma_req}, 16'h0);
    set_flags('0);

    // R2 readback
    wr(1, 16'hFFFF);
    chk("R2 readback", ctrl2_rd, 16'h1F3F);
    chk("R2 freq", {10'h0, freq}, 16'h003F);
    wr(1, 16'h0000);

    // R3 enable same edge
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 0;
    chk("R3 enable", {15'h0, periph_active}, 16'h1);

    for (int i = 0; i < NV; i++) begin
      wr(1, VEC[i][29:14]);
      set_flags(VEC[i][13:3]);
      @(negedge clk);
      chk($sformatf("R5-vector %0d evt/err/dma", i), {13'h0, evt_irq, err_irq, dma_req},
          {13'h0, VEC[i][2:0]});
      set_flags('0);
    end

    // R10 last-transfer NACK
    wr(1, 16'h1000);
    dma_eot = 1;
    @(negedge clk);
    dma_eot = 0;
    chk("R10 nack pulse", {15'h0, nack_last}, 16'h1);
    chk("R10 last cleared", ctrl2_rd, 16'h0000);
    @(negedge clk);
    chk("R10 single cycle", {15'h0, nack_last}, 16'h0);
    dma_eot = 1;
    @(negedge clk);
    @(negedge clk);
    dma_eot = 0;
    chk("R10 no last no nack", {15'h0, nack_last}, 16'h0);

    // R3 R11 deferred disable
    wr(1, 16'h1800);
    bus_idle = 0;
    txe = 1;
    wr(0, 16'h0000);
    @(negedge clk);
    chk("R3 still active", {15'h0, periph_active}, 16'h1);
    chk("R3 dma alive", {15'h0, dma_req}, 16'h1);
    chk("R11 last kept while busy", ctrl2_rd, 16'h1800);
    bus_idle = 1;
    @(negedge clk);
    chk("R3 inactive on idle", {15'h0, periph_active}, 16'h0);
    @(negedge clk);
    chk("R4 dma dropped", {15'h0, dma_req}, 16'h0);
    chk("R11 last cleared", ctrl2_rd, 16'h0800);
    txe = 0;

    // reset again mid-config
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 reset again", ctrl2_rd, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule